// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing side of a 2 KB byte-addressed nonvolatile store on a two-wire serial bus. The block watches SCL and SDA and decodes start and stop conditions. It checks the slave address byte against a fixed device type and two strap pins, and collects a two-byte word address. It can then take data into a one-page staging buffer, or return bytes from the store. The memory is an internal register array. Programming time is modelled by a busy counter. While that counter runs, the buffered page is committed to the array and the slave answers nobody, so a master can poll it until it acknowledges again.

The slave never drives SDA high. Its only output requests that the open-drain line be pulled low, and the surrounding pad logic resolves the wired-AND. The write-enable latch and the per-block lock bits come from a separate control-register block as plain inputs. SCL and SDA are oversampled by the system clock, so the bus must run well below one quarter of the clock rate.

Top module: `tws_eeprom`

## Requirements
- R1: After reset the slave does not pull SDA low.
- R2: The slave address byte is, MSB first, 1010 then a 0 bit, then two select bits that must equal `dev_sel_i[1:0]` (bit 2 = `dev_sel_i[1]`, bit 1 = `dev_sel_i[0]`), then the R/W bit in bit 0 (1 = read). Any other value receives no acknowledge, and the slave ignores the following bytes until the next start.
- R3: A write transfer carries a high address byte whose bits 2:0 give address bits 10:8, then a low address byte giving bits 7:0. Both are acknowledged, and a single data byte then lands at that address.
- R4: In a write, each accepted data byte advances only the low 6 address bits, so the data wraps inside its 64-byte page. For example, 12 bytes from offset 60 fill offsets 60..63 and then 0..7, and the next current-address read returns offset 8.
- R5: When more than 64 data bytes are sent, later bytes overwrite earlier bytes of the same page. The stored value is the last byte sent for each offset.
- R6: A stop that follows at least one complete data byte and its acknowledge starts the write cycle. A stop before any complete data byte, or in the middle of a byte, writes nothing and starts no write cycle.
- R7: While the write cycle runs, no slave address is acknowledged. Acknowledges resume after `WR_CYCLES` clocks.
- R8: Reads return consecutive bytes. The address increments across the whole array and wraps from 0x7FF to 0x000.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and ends the transfer.
- R10: With `wr_en_i` low, data bytes are not acknowledged and the array is left unchanged.
- R11: When the lock bit `blk_lock_i[a[10:8]]` of the target 256-byte block is set, data bytes are not acknowledged and the array is left unchanged.
- R12: A write transfer stopped right after the two address bytes only loads the address pointer. The next current-address read starts there, and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Resolved serial data line |
| dev_sel_i | input | 2 | Strap value the address select bits must match |
| wr_en_i | input | 1 | Write-enable latch from the control register |
| blk_lock_i | input | 8 | One lock bit per 256-byte block |
| sda_low_o | output | 1 | Pull SDA low when set (open-drain model) |

## Verification
The write path is tested with a single byte, a page overrun of 70 bytes, a 12-byte run that starts at offset 60, and random lengths at random addresses. These cases tell in-page wrapping apart from carry into the next page, and last-write-wins apart from first-write-wins. Stops are placed after the address bytes, in the middle of a data byte, and after a whole data byte. Each placement is followed by an immediate poll and a read-back, which separates pointer loading from a commit and from a discard. Reads that cross 0x7FF and random reads against a bench model check full-array increment. Transfers with the enable cleared, with a block locked, and with mismatched addresses check that the slave withholds the acknowledge and the array stays unchanged.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT
  } bus_st_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/tws_line_mon.sv
module tws_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_p <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_p <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_p <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tws_page_eng.sv
module tws_page_eng #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     ld_i,
  input  logic [PAGE_W-1:0]        ld_idx_i,
  input  logic [7:0]               ld_dat_i,
  input  logic                     go_i,
  input  logic [ADDR_W-PAGE_W-1:0] pg_i,
  output logic                     busy_o,
  output logic                     we_o,
  output logic [ADDR_W-1:0]        waddr_o,
  output logic [7:0]               wdat_o
);

  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pval_q, pval_n;
  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  bcnt_q, bcnt_n;
  logic [PAGE_W:0]   cidx_q, cidx_n;
  logic [PG_W-1:0]   pg_q, pg_n;

  always_comb begin
    pval_n = pval_q;
    busy_n = busy_q;
    bcnt_n = bcnt_q;
    cidx_n = cidx_q;
    pg_n   = pg_q;
    if (clr_i) begin
      pval_n = '0;
    end else if (ld_i) begin
      pval_n[ld_idx_i] = 1'b1;
    end
    if (go_i) begin
      busy_n = 1'b1;
      bcnt_n = CNT_W'(WR_CYCLES - 1);
      cidx_n = '0;
      pg_n   = pg_i;
    end else if (busy_q) begin
      if (!cidx_q[PAGE_W]) begin
        cidx_n = cidx_q + (PAGE_W+1)'(1);
      end
      if (bcnt_q == '0) begin
        busy_n = 1'b0;
      end else begin
        bcnt_n = bcnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval_q <= '0;
      busy_q <= 1'b0;
      bcnt_q <= '0;
      cidx_q <= '0;
      pg_q   <= '0;
    end else begin
      pval_q <= pval_n;
      busy_q <= busy_n;
      bcnt_q <= bcnt_n;
      cidx_q <= cidx_n;
      pg_q   <= pg_n;
    end
  end

  // staging storage carries no reset; validity is tracked in pval_q
  always_ff @(posedge clk) begin
    if (ld_i) begin
      pbuf[ld_idx_i] <= ld_dat_i;
    end
  end

  assign busy_o  = busy_q;
  assign we_o    = busy_q & ~cidx_q[PAGE_W] & pval_q[cidx_q[PAGE_W-1:0]];
  assign waddr_o = {pg_q, cidx_q[PAGE_W-1:0]};
  assign wdat_o  = pbuf[cidx_q[PAGE_W-1:0]];

endmodule

// File: rtl/tws_array.sv
module tws_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdat_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdat_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdat_i;
    end
  end

  assign rdat_o = mem[raddr_i];

endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom
  import tws_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int BLK_W     = 3,
  parameter int WR_CYCLES = 300
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            dev_sel_i,
  input  logic                  wr_en_i,
  input  logic [(1<<BLK_W)-1:0] blk_lock_i,
  output logic                  sda_low_o
);

  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic eng_busy, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0] mem_wdat, mem_rd;

  bus_st_t           st_q, st_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [7:0]        shr_q, shr_n;
  logic [7:0]        txb_q, txb_n;
  logic              rw_q, rw_n;
  logic              ack_q, ack_n;
  logic              got_q, got_n;
  logic              sda_low_q, sda_low_n;
  logic [HI_W-1:0]   ahi_q, ahi_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              buf_clr, buf_ld, wr_go, rd_ld;
  logic              lock_hit, dev_hit, dat_ok;

  tws_line_mon u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  tws_page_eng #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .WR_CYCLES(WR_CYCLES)
  ) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (buf_clr),
    .ld_i    (buf_ld),
    .ld_idx_i(ptr_q[PAGE_W-1:0]),
    .ld_dat_i(shr_q),
    .go_i    (wr_go),
    .pg_i    (ptr_q[ADDR_W-1:PAGE_W]),
    .busy_o  (eng_busy),
    .we_o    (mem_we),
    .waddr_o (mem_waddr),
    .wdat_o  (mem_wdat)
  );

  tws_array #(
    .ADDR_W(ADDR_W)
  ) u_mem (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdat_i (mem_wdat),
    .raddr_i(ptr_q),
    .rdat_o (mem_rd)
  );

  assign lock_hit = blk_lock_i[ptr_q[ADDR_W-1 -: BLK_W]];
  assign dev_hit  = (shr_q[7:1] == {DEV_TYPE, 1'b0, dev_sel_i}) && !eng_busy;
  assign dat_ok   = wr_en_i && !lock_hit;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    shr_n     = shr_q;
    txb_n     = txb_q;
    rw_n      = rw_q;
    ack_n     = ack_q;
    got_n     = got_q;
    sda_low_n = sda_low_q;
    ahi_n     = ahi_q;
    ptr_n     = ptr_q;
    buf_clr   = 1'b0;
    buf_ld    = 1'b0;
    wr_go     = 1'b0;
    rd_ld     = 1'b0;
    if (bus_stop) begin
      // commit only on a byte boundary after at least one accepted byte
      wr_go     = (st_q == S_WDAT) && got_q && (cnt_q <= 4'd1);
      st_n      = S_IDLE;
      cnt_n     = '0;
      sda_low_n = 1'b0;
    end else if (bus_start) begin
      st_n      = S_DEV;
      cnt_n     = '0;
      got_n     = 1'b0;
      sda_low_n = 1'b0;
    end else if (st_q != S_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < 4'd8) begin
          shr_n = {shr_q[6:0], sda_s};
        end else if (st_q == S_RDAT) begin
          ack_n = ~sda_s;
        end
        cnt_n = cnt_q + 4'd1;
      end else if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          unique case (st_q)
            S_DEV: begin
              ack_n     = dev_hit;
              rw_n      = shr_q[0];
              sda_low_n = dev_hit;
            end
            S_AHI: begin
              ack_n     = 1'b1;
              ahi_n     = shr_q[HI_W-1:0];
              sda_low_n = 1'b1;
            end
            S_ALO: begin
              ack_n     = 1'b1;
              ptr_n     = {ahi_q, shr_q};
              buf_clr   = 1'b1;
              sda_low_n = 1'b1;
            end
            S_WDAT: begin
              ack_n     = dat_ok;
              sda_low_n = dat_ok;
              if (dat_ok) begin
                buf_ld = 1'b1;
                ptr_n  = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
            end
            default: begin
              sda_low_n = 1'b0;
            end
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_n     = '0;
          sda_low_n = 1'b0;
          unique case (st_q)
            S_DEV: begin
              if (!ack_q) begin
                st_n = S_IDLE;
              end else if (rw_q) begin
                st_n      = S_RDAT;
                rd_ld     = 1'b1;
                txb_n     = mem_rd;
                ptr_n     = ptr_q + ADDR_W'(1);
                sda_low_n = ~mem_rd[7];
              end else begin
                st_n = S_AHI;
              end
            end
            S_AHI: st_n = S_ALO;
            S_ALO: st_n = S_WDAT;
            S_WDAT: begin
              if (ack_q) begin
                got_n = 1'b1;
              end else begin
                st_n = S_IDLE;
              end
            end
            default: begin
              if (ack_q) begin
                rd_ld     = 1'b1;
                txb_n     = mem_rd;
                ptr_n     = ptr_q + ADDR_W'(1);
                sda_low_n = ~mem_rd[7];
              end else begin
                st_n = S_IDLE;
              end
            end
          endcase
        end else if (st_q == S_RDAT) begin
          // bit 7-k is sent after the k-th falling edge (7-k == ~k on 3 bits)
          sda_low_n = ~txb_q[~cnt_q[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      shr_q     <= '0;
      txb_q     <= '0;
      rw_q      <= 1'b0;
      ack_q     <= 1'b0;
      got_q     <= 1'b0;
      sda_low_q <= 1'b0;
      ahi_q     <= '0;
      ptr_q     <= '0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      shr_q     <= shr_n;
      txb_q     <= txb_n;
      rw_q      <= rw_n;
      ack_q     <= ack_n;
      got_q     <= got_n;
      sda_low_q <= sda_low_n;
      ahi_q     <= ahi_n;
      ptr_q     <= ptr_n;
    end
  end

  assign sda_low_o = sda_low_q;

endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk
  import tws_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input bus_st_t           st,
  input logic              sda_low,
  input logic              busy,
  input logic              mem_we,
  input logic              go,
  input logic              buf_ld,
  input logic              rd_ld,
  input logic [ADDR_W-1:0] ptr
);

  // R9: outside a transfer the line is never held low
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_low);

  // R7: no address acknowledge while the write cycle runs
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_DEV) |-> !sda_low);

  // R6: array updates only happen inside a write cycle
  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6: a qualifying stop opens the write cycle
  p_go_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R4: page number is frozen while data bytes are taken
  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && $past(st == S_WDAT)) |->
      ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  // R8: each byte handed out advances the pointer by one over the full array
  p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ld |=> ptr == $past(ptr) + ADDR_W'(1));

  // R10: every buffered byte is acknowledged
  p_ack_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ld |=> sda_low);

endmodule

bind tws_eeprom tws_eeprom_chk #(
  .ADDR_W(ADDR_W),
  .PAGE_W(PAGE_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .st     (st_q),
  .sda_low(sda_low_o),
  .busy   (eng_busy),
  .mem_we (mem_we),
  .go     (wr_go),
  .buf_ld (buf_ld),
  .rd_ld  (rd_ld),
  .ptr    (ptr_q)
);

// File: tb/tws_eeprom_bench.sv
`timescale 1ns/1ps
module tws_eeprom_bench;

  localparam int Q  = 6;
  localparam int WD = 190000;

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [1:0] sel;
  logic       wr_en;
  logic [7:0] lock;
  logic       sda_low;
  logic       sda_line;

  int nchk  = 0;
  int nfail = 0;

  logic [7:0] mdl [2048];
  bit         kn  [2048];
  int         mptr;
  logic [7:0] wbuf [80];

  assign sda_line = sda_m & ~sda_low;

  tws_eeprom u_tws_eeprom (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .dev_sel_i (sel),
    .wr_en_i   (wr_en),
    .blk_lock_i(lock),
    .sda_low_o (sda_low)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pg_addr(input int a, input int i);
    return (a & ~63) | ((a + i) & 63);
  endfunction

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, 1'b0, sel, rd};
  endfunction

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic bbits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0;
    end
  endtask

  task automatic bsend(input logic [7:0] b, output bit ack);
    bbits(b, 8);
    sda_m = 1'b1; hold();
    scl_m = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack = (sda_line == 1'b0);
    repeat (Q/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic brecv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl_m = 1'b1;
      repeat (Q/2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = ~mack; hold();
    scl_m = 1'b1; hold();
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic write_bytes(input int a, input int n, output bit dack);
    bit k;
    bstart();
    bsend(dev(1'b0), k); chk(k, "R2 dev write ack", k, 1);
    bsend(8'(a >> 8), k); chk(k, "R3 high addr ack", k, 1);
    bsend(8'(a), k);      chk(k, "R3 low addr ack", k, 1);
    dack = 1'b1;
    for (int i = 0; i < n; i++) begin
      bsend(wbuf[i], k);
      dack &= k;
    end
    bstop();
  endtask

  task automatic commit(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      mdl[pg_addr(a, i)] = wbuf[i];
      kn[pg_addr(a, i)]  = 1'b1;
    end
    mptr = pg_addr(a, n);
  endtask

  task automatic wait_ready(output int nacks);
    bit k;
    nacks = 0;
    for (int t = 0; t < 40; t++) begin
      bstart();
      bsend(dev(1'b0), k);
      bstop();
      if (k) break;
      nacks++;
    end
    chk(k, "R7 ack resumes after write cycle", k, 1);
  endtask

  task automatic read_seq(input int n, input string tag);
    bit k;
    logic [7:0] b;
    bstart();
    bsend(dev(1'b1), k); chk(k, "R2 dev read ack", k, 1);
    for (int i = 0; i < n; i++) begin
      brecv(i != n - 1, b);
      if (kn[mptr]) chk(b === mdl[mptr], tag, b, mdl[mptr]);
      mptr = (mptr + 1) & 2047;
    end
    bstop();
  endtask

  task automatic set_ptr(input int a);
    bit k;
    bstart();
    bsend(dev(1'b0), k);
    bsend(8'(a >> 8), k);
    bsend(8'(a), k);
    mptr = a;
  endtask

  task automatic read_rand(input int a, input int n, input string tag);
    set_ptr(a);
    read_seq(n, tag);
  endtask

  task automatic poll_now(input string tag);
    bit k;
    bstart();
    bsend(dev(1'b0), k);
    bstop();
    chk(k, tag, k, 1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit k, d;
    int nk;
    logic [7:0] b;
    void'($urandom(32'd1729));
    for (int i = 0; i < 2048; i++) kn[i] = 1'b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    sel = 2'b10; wr_en = 1'b1; lock = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_low == 1'b0, "R1 released after reset", sda_low, 0);

    // R2: wrong select bits, wrong type, then bytes inside an ignored transfer
    bstart();
    bsend({4'b1010, 1'b0, ~sel, 1'b0}, k); chk(!k, "R2 select mismatch nack", k, 0);
    bsend(dev(1'b0), k); chk(!k, "R2 ignored until next start", k, 0);
    bstop();
    bstart();
    bsend({4'b1011, 1'b0, sel, 1'b0}, k); chk(!k, "R2 type mismatch nack", k, 0);
    bstop();

    // R3: single byte
    wbuf[0] = 8'h5A;
    write_bytes(11'h2C7, 1, d); chk(d, "R3 data ack", d, 1);
    commit(11'h2C7, 1);
    wait_ready(nk);
    chk(nk > 0, "R7 busy nack seen", nk, 1);
    read_rand(11'h2C7, 1, "R3 byte read back");

    // R5: 70 bytes overrun the page
    for (int i = 0; i < 70; i++) wbuf[i] = 8'($urandom);
    write_bytes(11'h145, 70, d); chk(d, "R5 all data ack", d, 1);
    commit(11'h145, 70);
    wait_ready(nk);
    read_rand(11'h140, 64, "R5 page overwrite");

    // R4: 12 bytes from offset 60
    for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'hC0 + i);
    write_bytes(11'h17C, 12, d); chk(d, "R4 data ack", d, 1);
    commit(11'h17C, 12);
    wait_ready(nk);
    chk(nk > 0, "R7 polling nack", nk, 1);
    chk(mptr == 11'h148, "R4 pointer model", mptr, 11'h148);
    read_seq(1, "R4 current read at offset 8");
    read_rand(11'h140, 64, "R4 in-page wrap");

    // R6: stop in the middle of a data byte
    set_ptr(11'h2C7);
    bbits(8'hFF, 4);
    bstop();
    poll_now("R6 no write cycle after partial byte");
    read_rand(11'h2C7, 1, "R6 partial byte discarded");

    // R12: set current address
    set_ptr(11'h150);
    bstop();
    poll_now("R12 no write cycle after address only");
    mptr = 11'h150;
    read_seq(3, "R12 current read from loaded pointer");

    // R10: enable cleared
    wr_en = 1'b0;
    wbuf[0] = 8'h33;
    write_bytes(11'h2C7, 1, d); chk(!d, "R10 data nack", d, 0);
    poll_now("R10 no write cycle");
    wr_en = 1'b1;
    read_rand(11'h2C7, 1, "R10 array unchanged");

    // R11: locked block 2, open block 3
    lock = 8'b0000_0100;
    wbuf[0] = 8'h77;
    write_bytes(11'h2C7, 1, d); chk(!d, "R11 locked data nack", d, 0);
    poll_now("R11 no write cycle");
    read_rand(11'h2C7, 1, "R11 locked unchanged");
    wbuf[0] = 8'h3C;
    write_bytes(11'h3A0, 1, d); chk(d, "R11 open block ack", d, 1);
    commit(11'h3A0, 1);
    wait_ready(nk);
    lock = '0;
    read_rand(11'h3A0, 1, "R11 open block written");

    // R8: wrap at top of array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_bytes(11'h7FE, 2, d); commit(11'h7FE, 2); wait_ready(nk);
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    write_bytes(11'h000, 2, d); commit(11'h000, 2); wait_ready(nk);
    read_rand(11'h7FE, 4, "R8 wrap 7FF to 000");

    // R9: master nack releases the line
    set_ptr(11'h7FF);
    bstart();
    bsend(dev(1'b1), k);
    brecv(1'b0, b);
    chk(b === 8'h22, "R9 byte before nack", b, 8'h22);
    hold();
    chk(sda_low == 1'b0, "R9 line released after nack", sda_low, 0);
    bstop();
    poll_now("R9 slave idle after read");

    // random traffic
    for (int it = 0; it < 18; it++) begin
      int a, n;
      a = int'($urandom % 2048);
      n = 1 + int'($urandom % 16);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_bytes(a, n, d); chk(d, "R6 random write ack", d, 1);
      commit(a, n);
      wait_ready(nk);
      if (it % 3 == 0) begin
        read_seq(2, "R4 random current read");
      end
      read_rand(pg_addr(a, 0), 1 + int'($urandom % 8), "R8 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule